// File: doc/BRIEF.md
# Overlay window framebuffer burst address generator

This block walks the framebuffer of one overlay window and issues the read bursts that fetch it. Each frame begins with a frame-start pulse. The walk then goes line by line: it issues bursts until the bytes of one visible line (the page width) are covered, jumps over the line gap to the first byte of the next line, and halts once the next address reaches the frame end address. The maximum burst size depends on the pixel-depth mode. When the remaining bytes of a line cannot fill a whole maximum burst, the last burst of that line is shortened.

Bursts leave the block on a valid/ready handshake carrying an address and a length in 32-bit words. A request stays on the outputs until it is accepted. A separate comparator reports whether the current display pixel falls inside the window rectangle, with both corners included.

The walk is a three-state machine:

- IDLE: waiting for a frame.
- ISSUE: a request is presented.
- DONE: the frame is complete.

Its transitions are:

- LOAD: enable and frame-start together. The machine goes to ISSUE, or to DONE when the start address is not below the end address. LOAD can be taken from any state.
- FINISH: ISSUE to DONE, taken when the address after an accepted burst reaches the end address.
- DROP: any state to IDLE, taken when enable is low.

Top module: `win_dma_addr_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame-start, req_valid is low.
- R2: A frame-start with win_en high restarts the walk. In the following cycle req_valid is high with req_addr equal to start_addr, as long as start_addr is below end_addr.
- R3: While win_en is low, req_valid is low and frame-start pulses are ignored. Dropping win_en in the middle of a frame abandons that frame, and no request appears until the next frame-start with win_en high.
- R4: The maximum burst length in words is set by bpp_mode. Codes 0 (1 bpp) give 4. Codes 1, 2 and 3 (2, 4 and 8 bpp) give 8. Codes 4 (16 bpp), 5 (24 bpp) and 6 (32 bpp with alpha) give 16. The unrecognised code 7 falls back to 16.
- R5: Within a line, each burst has the maximum length or, if fewer words remain in the line, exactly the remaining words. After the burst that completes a line, the next address is the previous address, plus the burst bytes (4 per word), plus line_offset. page_width and line_offset are whole words; their two low bits are ignored.
- R6: Once an accepted burst moves the address to end_addr or beyond, no further request is issued until the next frame-start.
- R7: A request with req_ready low keeps req_addr and req_len unchanged in the next cycle. The address advances only when req_valid and req_ready are both high.
- R8: A frame-start that arrives in the same cycle as a request acceptance restarts the walk at start_addr; that acceptance does not advance the address.
- R9: win_active is high exactly when win_en is high and tl_x <= pix_x <= br_x and tl_y <= pix_y <= br_y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable |
| frame_start | input | 1 | One-cycle frame-start pulse |
| bpp_mode | input | 3 | Pixel depth code |
| start_addr | input | ADDR_W | Frame start byte address |
| end_addr | input | ADDR_W | Frame end byte address (exclusive) |
| page_width | input | LINE_W | Visible bytes per line |
| line_offset | input | LINE_W | Bytes skipped between lines |
| tl_x | input | COORD_W | Window left column (inclusive) |
| tl_y | input | COORD_W | Window top row (inclusive) |
| br_x | input | COORD_W | Window right column (inclusive) |
| br_y | input | COORD_W | Window bottom row (inclusive) |
| pix_x | input | COORD_W | Current display column |
| pix_y | input | COORD_W | Current display row |
| win_active | output | 1 | Current pixel lies inside the window |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | ADDR_W | Burst byte address |
| req_len | output | LEN_W | Burst length in words |

## Verification
A restart and a burst acceptance can land in the same cycle. The bench provokes this by pulsing frame-start in the middle of a frame while req_ready is held high during a presented request. The acceptance in that cycle must be discarded: the next request carries start_addr again, and the queue of expected bursts is replaced by a fresh frame. The bench also stalls acceptance with a pseudo-random ready pattern, so that the line-end jump and the end-of-frame stop both fall on stalled and on accepted cycles.

// File: rtl/win_dma_pkg.sv
package win_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } walk_state_e;

    localparam int MAX_BURST_WORDS = 16;
    localparam int LEN_W           = $clog2(MAX_BURST_WORDS + 1);
endpackage

// File: rtl/win_burst_sel.sv
module win_burst_sel
    import win_dma_pkg::*;
(
    input  logic [2:0]       bpp_mode,
    output logic [LEN_W-1:0] max_words
);
    always_comb begin
        unique case (bpp_mode)
            3'd0:                max_words = LEN_W'(4);
            3'd1, 3'd2, 3'd3:    max_words = LEN_W'(8);
            default:             max_words = LEN_W'(MAX_BURST_WORDS);
        endcase
    end
endmodule

// File: rtl/win_rect_hit.sv
module win_rect_hit #(
    parameter int COORD_W = 12
) (
    input  logic               win_en,
    input  logic [COORD_W-1:0] tl_x,
    input  logic [COORD_W-1:0] tl_y,
    input  logic [COORD_W-1:0] br_x,
    input  logic [COORD_W-1:0] br_y,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               hit
);
    logic in_x, in_y;
    always_comb begin
        in_x = (pix_x >= tl_x) && (pix_x <= br_x);
        in_y = (pix_y >= tl_y) && (pix_y <= br_y);
        hit  = win_en && in_x && in_y;
    end
endmodule

// File: rtl/win_addr_fsm.sv
module win_addr_fsm
    import win_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_en,
    input  logic              frame_start,
    input  logic [LEN_W-1:0]  max_words,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [LINE_W-1:0] page_width,
    input  logic [LINE_W-1:0] line_offset,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len
);
    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic [LINE_W-1:0] rem_q, rem_nx;
    logic [LINE_W-1:0] rem_words, burst_bytes, pw_aligned, off_aligned;
    logic [LEN_W-1:0]  cur_len;
    logic              line_end, load, accept;

    // burst sizing and next position
    always_comb begin
        pw_aligned  = {page_width[LINE_W-1:2], 2'b00};
        off_aligned = {line_offset[LINE_W-1:2], 2'b00};
        rem_words   = {2'b00, rem_q[LINE_W-1:2]};
        cur_len     = (rem_words < LINE_W'(max_words)) ? rem_words[LEN_W-1:0] : max_words;
        burst_bytes = LINE_W'(cur_len) << 2;
        line_end    = (rem_words == LINE_W'(cur_len));
        addr_nx     = addr_q + ADDR_W'(burst_bytes) + (line_end ? ADDR_W'(off_aligned) : '0);
        rem_nx      = line_end ? pw_aligned : (rem_q - burst_bytes);
        load        = win_en && frame_start;
        accept      = req_valid && req_ready;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!win_en) begin
            state_d = ST_IDLE;                                   // DROP
        end else if (load) begin
            state_d = (start_addr < end_addr) ? ST_ISSUE : ST_DONE; // LOAD
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ISSUE: if (accept && (addr_nx >= end_addr)) state_d = ST_DONE; // FINISH
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= start_addr;
            rem_q  <= pw_aligned;
        end else if (accept) begin
            addr_q <= addr_nx;
            rem_q  <= rem_nx;
        end
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_ISSUE) && win_en;
        req_addr  = addr_q;
        req_len   = cur_len;
    end

    AST_START_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && frame_start && (start_addr < end_addr)) |=> (state_q == ST_ISSUE && addr_q == $past(start_addr))); // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> !req_valid); // R3
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_start && win_en) |=> $stable(req_addr)); // R7
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !frame_start) |=> !req_valid); // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len <= max_words)); // R5
endmodule

// File: rtl/win_dma_addr_gen.sv
module win_dma_addr_gen
    import win_dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 16,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_en,
    input  logic               frame_start,
    input  logic [2:0]         bpp_mode,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [ADDR_W-1:0]  end_addr,
    input  logic [LINE_W-1:0]  page_width,
    input  logic [LINE_W-1:0]  line_offset,
    input  logic [COORD_W-1:0] tl_x,
    input  logic [COORD_W-1:0] tl_y,
    input  logic [COORD_W-1:0] br_x,
    input  logic [COORD_W-1:0] br_y,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               win_active,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len
);
    logic [LEN_W-1:0] max_words;

    win_burst_sel u_burst (
        .bpp_mode (bpp_mode),
        .max_words(max_words)
    );

    win_rect_hit #(.COORD_W(COORD_W)) u_rect (
        .win_en(win_en), .tl_x(tl_x), .tl_y(tl_y), .br_x(br_x), .br_y(br_y),
        .pix_x(pix_x), .pix_y(pix_y), .hit(win_active)
    );

    win_addr_fsm #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .frame_start(frame_start),
        .max_words(max_words), .start_addr(start_addr), .end_addr(end_addr),
        .page_width(page_width), .line_offset(line_offset),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len)
    );
endmodule

// File: tb/test_win_dma_addr_gen.sv
module test_win_dma_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        win_en = 0, frame_start = 0, req_ready = 0;
    logic [2:0]  bpp_mode = 0;
    logic [31:0] start_addr = 0, end_addr = 0;
    logic [15:0] page_width = 0, line_offset = 0;
    logic [11:0] tl_x = 0, tl_y = 0, br_x = 0, br_y = 0, pix_x = 0, pix_y = 0;
    logic        win_active, req_valid;
    logic [31:0] req_addr;
    logic [4:0]  req_len;

    int checks = 0, errors = 0;
    logic [36:0] exp_q[$];
    string tag = "R1";
    bit rdy_force = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    always #4 clk = ~clk;

    win_dma_addr_gen i_win_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .frame_start(frame_start),
        .bpp_mode(bpp_mode), .start_addr(start_addr), .end_addr(end_addr),
        .page_width(page_width), .line_offset(line_offset),
        .tl_x(tl_x), .tl_y(tl_y), .br_x(br_x), .br_y(br_y),
        .pix_x(pix_x), .pix_y(pix_y), .win_active(win_active),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len)
    );

    task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // pseudo-random ready, changed at the falling edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready = rdy_force | lfsr[0] | lfsr[3];
    end

    // monitor: sample mid low phase
    bit          stall_seen = 0;
    logic [31:0] stall_addr;
    logic [4:0]  stall_len;
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (stall_seen && req_valid) begin
                chk("R7 hold addr", req_addr, stall_addr);
                chk("R7 hold len", req_len, stall_len);
            end
            stall_seen = 0;
            if (req_valid && exp_q.size() == 0) begin
                chk({tag, " unexpected request"}, req_addr, 64'hFFFF_FFFF_FFFF);
            end else if (req_valid && !frame_start) begin
                if (req_ready) begin
                    logic [36:0] e;
                    e = exp_q.pop_front();
                    chk({tag, " addr"}, req_addr, e[36:5]);
                    chk({tag, " len"}, req_len, e[4:0]);
                end else begin
                    stall_seen = 1;
                    stall_addr = req_addr;
                    stall_len  = req_len;
                end
            end
        end
    end

    function automatic int max_of(input logic [2:0] m);
        if (m == 0) return 4;
        if (m <= 3) return 8;
        return 16;
    endfunction

    // expected bursts from the requirements
    task automatic build(input logic [2:0] m, input int st, input int pw, input int off, input int lines);
        int a, rem, len, mb, en;
        mb = max_of(m);
        en = st + (pw + off) * lines;
        bpp_mode = m; start_addr = st; end_addr = en;
        page_width = pw; line_offset = off;
        a = st; rem = pw;
        while (a < en) begin
            len = (rem / 4 < mb) ? rem / 4 : mb;
            exp_q.push_back({a[31:0], len[4:0]});
            if (rem == len * 4) begin a = a + len * 4 + off; rem = pw; end
            else begin a = a + len * 4; rem = rem - len * 4; end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic drain(input string t);
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
        chk({t, " all bursts seen"}, exp_q.size(), 0);
        repeat (20) @(negedge clk);
    endtask

    task automatic frame(input string t, input logic [2:0] m, input int st, input int pw, input int off, input int lines);
        tag = t;
        build(m, st, pw, off, lines);
        pulse_start();
        drain(t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk("R1 valid in reset", req_valid, 0);
        chk("R9 active while disabled", win_active, 0);
        @(negedge clk); rst_n = 1;
        repeat (3) @(negedge clk);
        #3;
        chk("R1 valid after reset", req_valid, 0);

        // R9 inclusive corners
        @(negedge clk);
        win_en = 1; tl_x = 10; tl_y = 20; br_x = 49; br_y = 29;
        pix_x = 10; pix_y = 20; #1; chk("R9 top-left", win_active, 1);
        pix_x = 49; pix_y = 29; #1; chk("R9 bottom-right", win_active, 1);
        pix_x = 50; pix_y = 25; #1; chk("R9 right of window", win_active, 0);
        pix_x = 30; pix_y = 19; #1; chk("R9 above window", win_active, 0);
        pix_x = 30; pix_y = 30; #1; chk("R9 below window", win_active, 0);
        pix_x = 9;  pix_y = 25; #1; chk("R9 left of window", win_active, 0);
        win_en = 0; pix_x = 30; pix_y = 25; #1; chk("R9 gated by enable", win_active, 0);
        win_en = 1;

        frame("R2 R5 mode0", 3'd0, 32'h1000, 40, 24, 3);
        frame("R4 mode4", 3'd4, 32'h2000, 100, 28, 2);
        frame("R4 fallback", 3'd7, 32'h3000, 64, 0, 2);
        frame("R5 mode2", 3'd2, 32'h4000, 48, 16, 2);
        frame("R6 mode6", 3'd6, 32'h5000, 72, 8, 1);

        // R3: enable low ignores frame-start
        tag = "R3 disabled";
        @(negedge clk); win_en = 0;
        pulse_start();
        repeat (30) @(negedge clk);
        #3; chk("R3 no request while disabled", req_valid, 0);

        // R3: dropping enable mid-frame abandons it
        @(negedge clk); win_en = 1;
        tag = "R3 drop";
        build(3'd1, 32'h6000, 160, 32, 4);
        pulse_start();
        while (exp_q.size() > 12) @(negedge clk);
        win_en = 0; exp_q.delete();
        repeat (5) @(negedge clk);
        win_en = 1;
        repeat (20) @(negedge clk);
        #3; chk("R3 abandoned frame stays quiet", req_valid, 0);

        // R8: restart collides with an acceptance
        tag = "R8 restart";
        build(3'd3, 32'h7000, 96, 32, 3);
        pulse_start();
        while (exp_q.size() > 6) @(negedge clk);
        rdy_force = 1;
        while (!req_valid) @(negedge clk);
        exp_q.delete();
        build(3'd3, 32'h7000, 96, 32, 3);
        frame_start = 1;
        #3; chk("R8 collision cycle has acceptance", req_valid & req_ready, 1);
        @(negedge clk); frame_start = 0; rdy_force = 0;
        #3; chk("R8 restart address", req_addr, 32'h7000);
        drain("R8 restart");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule